// File: doc/BRIEF.md
# Segmented DAC Code Decoder

This block turns a 12-bit sample word into the switch-control pattern of a segmented current-steering converter. The top eight bits select how many of 255 equal unit cells are on. Each unit cell carries sixteen LSB of weight, and the cells always form a contiguous thermometer pattern. The bottom four bits drive a small set of seven unequal cells, with weights 1, 1, 1, 2, 2, 4 and 4. These cells are split-coded rather than binary-weighted, so a mid-scale step changes only a few cells.

When randomization is enabled, a pseudo-random rotation picks which of the equal-weight LSB cells carry a given code. The cells chosen change from sample to sample, but the weight presented for each code stays exactly the same. The thermometer segment and the LSB segment go through a shared output register, so both segments switch on the same clock edge. A delayed valid flag marks each new output pattern.

Top module: `seg_dac_decoder`

## Requirements
- R1: While reset is asserted, `msbCtrl`, `lsbCtrl` and `validOut` are all zero.
- R2: After a sample is accepted, bit i of `msbCtrl` is 1 exactly when the sample's upper eight bits, read as an unsigned value, are greater than i (i = 0..254).
- R3: `lsbCtrl` bit positions have these weights: bits 0, 1 and 2 weigh 1; bits 3 and 4 weigh 2; bits 5 and 6 weigh 4. For a sample accepted with `randEn` low, `lsbCtrl` equals the following hex values for low nibbles 0 to 15: 00, 01, 08, 09, 20, 21, 28, 29, 38, 39, 68, 69, 78, 79, 7B, 7F.
- R4: For a sample accepted with `randEn` high, each weight group of `lsbCtrl` has the same number of active cells as the R3 pattern for the same nibble. The groups are bits 2:0, bits 4:3 and bits 6:5.
- R5: For every code, in either mode, the weight of the output is 16 times the number of set bits in `msbCtrl`, plus the weights of the set `lsbCtrl` bits. This weight equals the accepted sample.
- R6: A sample presented with `validIn` high at one rising edge appears on `msbCtrl` and `lsbCtrl` after the next rising edge. `validOut` is high for exactly that cycle, and both segments update on that same edge.
- R7: When no sample reaches the output stage, `msbCtrl` and `lsbCtrl` hold their previous values and `validOut` is low.
- R8: The rotation source is a nonzero 16-bit maximal-length shift register. It advances only on accepted samples. With `randEn` high, repeated samples of code 1 place the active weight-1 cell in at least two different positions. Repeated samples of code 2 use both weight-2 cells.
- R9: With `randEn` low, the step from code 7 to code 8 changes at most two `lsbCtrl` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 12 | Unsigned sample word |
| validIn | input | 1 | Sample strobe for `dataIn` |
| randEn | input | 1 | Enables rotation of the equal-weight LSB cells |
| msbCtrl | output | 255 | Thermometer control for the unit cells |
| lsbCtrl | output | 7 | Control for the split-coded LSB cells |
| validOut | output | 1 | Marks a fresh output pattern |

## Verification
A sample is captured at one rising edge and is due on the outputs after the following edge. The bench keeps a queue of the inputs seen at each edge. Each expected pattern is drawn from the entry that is one edge older than the newest, and outputs are compared at the falling edge between edges, so they are never read while they change. When no fresh sample arrives, the bench carries the previous expectation forward. This checks the hold behaviour on the same timeline. Randomized patterns are judged by per-group cell counts and total weight rather than by exact bits, since the exact rotation is not a requirement.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

  localparam int LSB_BITS  = 4;
  localparam int LSB_ELEMS = 7;
  localparam int LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // Strobes and rotation choices handed from control to datapath
  typedef struct packed {
    logic       s1Load;
    logic       s2Load;
    logic [1:0] rot3;
    logic       swap2;
    logic       swap4;
  } dacStrobe_t;

  // Split-code pattern: bits 2:0 weigh 1, bits 4:3 weigh 2, bits 6:5 weigh 4.
  // Codes 7 and 8 differ by one weight-1 cell off and one weight-2 cell on.
  function automatic logic [LSB_ELEMS-1:0] splitCode(input logic [LSB_BITS-1:0] nib);
    logic [LSB_ELEMS-1:0] pat;
    case (nib)
      4'd0:    pat = 7'h00;
      4'd1:    pat = 7'h01;
      4'd2:    pat = 7'h08;
      4'd3:    pat = 7'h09;
      4'd4:    pat = 7'h20;
      4'd5:    pat = 7'h21;
      4'd6:    pat = 7'h28;
      4'd7:    pat = 7'h29;
      4'd8:    pat = 7'h38;
      4'd9:    pat = 7'h39;
      4'd10:   pat = 7'h68;
      4'd11:   pat = 7'h69;
      4'd12:   pat = 7'h78;
      4'd13:   pat = 7'h79;
      4'd14:   pat = 7'h7B;
      default: pat = 7'h7F;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/seg_therm_decode.sv
module seg_therm_decode #(
  parameter int MSB_BITS = 8,
  localparam int THERM_W = (1 << MSB_BITS) - 1
) (
  input  logic [MSB_BITS-1:0] codeIn,
  output logic [THERM_W-1:0]  thermOut
);

  // Halving recursion: with the top bit set, the lower half of the range is
  // all ones and the remaining bits decode the upper half. With it clear,
  // the upper half is zero and the remaining bits decode the lower half.
  // The levels below build that tree one input bit at a time.
  logic [THERM_W-1:0] lvl [0:MSB_BITS];

  assign lvl[0] = '0;

  for (genvar k = 0; k < MSB_BITS; k++) begin : g_level
    localparam int SPAN = 1 << k;
    localparam logic [THERM_W-1:0] FILL = {THERM_W{1'b1}} >> (THERM_W - SPAN);
    assign lvl[k+1] = codeIn[k] ? ((lvl[k] << SPAN) | FILL) : lvl[k];
  end

  assign thermOut = lvl[MSB_BITS];

endmodule

// File: rtl/seg_lsb_rotate.sv
module seg_lsb_rotate
  import seg_dac_pkg::*;
(
  input  logic [LSB_ELEMS-1:0] patIn,
  input  logic [1:0]           rot3,
  input  logic                 swap2,
  input  logic                 swap4,
  output logic [LSB_ELEMS-1:0] patOut
);

  logic [2:0] unitGrp;
  logic [1:0] twoGrp;
  logic [1:0] fourGrp;

  // Cyclic rotation among the three weight-1 cells: logical i -> physical (i+rot)%3
  always_comb begin
    case (rot3)
      2'd1:    unitGrp = {patIn[1], patIn[0], patIn[2]};
      2'd2:    unitGrp = {patIn[0], patIn[2], patIn[1]};
      default: unitGrp = patIn[2:0];
    endcase
  end

  assign twoGrp  = swap2 ? {patIn[3], patIn[4]} : patIn[4:3];
  assign fourGrp = swap4 ? {patIn[5], patIn[6]} : patIn[6:5];

  assign patOut = {fourGrp, twoGrp, unitGrp};

endmodule

// File: rtl/seg_dac_ctrl.sv
module seg_dac_ctrl
  import seg_dac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic       randEn,
  output dacStrobe_t strobe,
  output logic       validOut
);

  logic [LFSR_W-1:0] lfsrQ;
  logic              lfsrFb;
  logic              valid1Q;
  logic              validOutQ;
  logic [1:0]        rot3Q;
  logic              swap2Q;
  logic              swap4Q;
  logic [1:0]        rotPick;

  // Taps 16,14,13,11 give a maximal-length sequence
  assign lfsrFb  = lfsrQ[15] ^ lfsrQ[13] ^ lfsrQ[12] ^ lfsrQ[10];
  assign rotPick = (lfsrQ[1:0] == 2'd3) ? 2'd0 : lfsrQ[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ <= LFSR_SEED;
    end else if (validIn) begin
      lfsrQ <= {lfsrQ[LFSR_W-2:0], lfsrFb};
    end
  end

  // Rotation choice is captured alongside the sample so it meets the
  // decode stage together with it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rot3Q  <= 2'd0;
      swap2Q <= 1'b0;
      swap4Q <= 1'b0;
    end else if (validIn) begin
      rot3Q  <= randEn ? rotPick  : 2'd0;
      swap2Q <= randEn ? lfsrQ[2] : 1'b0;
      swap4Q <= randEn ? lfsrQ[3] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid1Q   <= 1'b0;
      validOutQ <= 1'b0;
    end else begin
      valid1Q   <= validIn;
      validOutQ <= valid1Q;
    end
  end

  assign strobe.s1Load = validIn;
  assign strobe.s2Load = valid1Q;
  assign strobe.rot3   = rot3Q;
  assign strobe.swap2  = swap2Q;
  assign strobe.swap4  = swap4Q;
  assign validOut      = validOutQ;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);  // R8

  AST_LFSR_STILL: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(lfsrQ));  // R8

  AST_IDENTITY_ROT: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !randEn) |=> (strobe.rot3 == 2'd0 && !strobe.swap2 && !strobe.swap4));  // R3

endmodule

// File: rtl/seg_dac_datapath.sv
module seg_dac_datapath
  import seg_dac_pkg::*;
#(
  parameter int MSB_BITS = 8,
  localparam int DATA_W  = MSB_BITS + LSB_BITS,
  localparam int THERM_W = (1 << MSB_BITS) - 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dacStrobe_t           strobe,
  input  logic [DATA_W-1:0]    dataIn,
  output logic [THERM_W-1:0]   msbCtrl,
  output logic [LSB_ELEMS-1:0] lsbCtrl
);

  logic [DATA_W-1:0]    code1Q;
  logic [THERM_W-1:0]   thermNext;
  logic [LSB_ELEMS-1:0] splitNext;
  logic [LSB_ELEMS-1:0] rotNext;
  logic [THERM_W-1:0]   msbQ;
  logic [LSB_ELEMS-1:0] lsbQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code1Q <= '0;
    end else if (strobe.s1Load) begin
      code1Q <= dataIn;
    end
  end

  seg_therm_decode #(.MSB_BITS(MSB_BITS)) u_therm (
    .codeIn   (code1Q[DATA_W-1:LSB_BITS]),
    .thermOut (thermNext)
  );

  assign splitNext = splitCode(code1Q[LSB_BITS-1:0]);

  seg_lsb_rotate u_rot (
    .patIn  (splitNext),
    .rot3   (strobe.rot3),
    .swap2  (strobe.swap2),
    .swap4  (strobe.swap4),
    .patOut (rotNext)
  );

  // Shared output register re-aligns both decode paths to one edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msbQ <= '0;
      lsbQ <= '0;
    end else if (strobe.s2Load) begin
      msbQ <= thermNext;
      lsbQ <= rotNext;
    end
  end

  assign msbCtrl = msbQ;
  assign lsbCtrl = lsbQ;

  AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (msbQ & (msbQ + 1'b1)) == '0);  // R2

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.s2Load |=> ($stable(msbQ) && $stable(lsbQ)));  // R7

  AST_GROUP_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.s2Load |=> ($countones(lsbQ[2:0]) == $past($countones(splitNext[2:0]))
                    && $countones(lsbQ[4:3]) == $past($countones(splitNext[4:3]))
                    && $countones(lsbQ[6:5]) == $past($countones(splitNext[6:5]))));  // R4

endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import seg_dac_pkg::*;
#(
  parameter int MSB_BITS = 8,
  localparam int DATA_W  = MSB_BITS + LSB_BITS,
  localparam int THERM_W = (1 << MSB_BITS) - 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic                 validIn,
  input  logic                 randEn,
  output logic [THERM_W-1:0]   msbCtrl,
  output logic [LSB_ELEMS-1:0] lsbCtrl,
  output logic                 validOut
);

  dacStrobe_t strobe;

  seg_dac_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .randEn   (randEn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  seg_dac_datapath #(.MSB_BITS(MSB_BITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .msbCtrl (msbCtrl),
    .lsbCtrl (lsbCtrl)
  );

  int outWeight;
  always_comb begin
    outWeight = (1 << LSB_BITS) * $countones(msbCtrl)
              + int'(lsbCtrl[0]) + int'(lsbCtrl[1]) + int'(lsbCtrl[2])
              + 2 * (int'(lsbCtrl[3]) + int'(lsbCtrl[4]))
              + 4 * (int'(lsbCtrl[5]) + int'(lsbCtrl[6]));
  end

  AST_WEIGHT_SUM: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> outWeight == int'($past(dataIn, 2)));  // R5

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    validIn |-> ##2 validOut);  // R6

endmodule

// File: tb/seg_dac_decoder_bench.sv
module seg_dac_decoder_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [11:0]  dataIn = '0;
  logic         validIn = 1'b0;
  logic         randEn = 1'b0;
  logic [254:0] msbCtrl;
  logic [6:0]   lsbCtrl;
  logic         validOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  seg_dac_decoder u_seg_dac_decoder (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .validIn(validIn),
    .randEn(randEn), .msbCtrl(msbCtrl), .lsbCtrl(lsbCtrl), .validOut(validOut)
  );

  // R3 identity patterns as stated in the requirement
  logic [6:0] idPat [16] = '{7'h00, 7'h01, 7'h08, 7'h09, 7'h20, 7'h21, 7'h28, 7'h29,
                             7'h38, 7'h39, 7'h68, 7'h69, 7'h78, 7'h79, 7'h7B, 7'h7F};

  typedef struct { logic v; logic [11:0] c; logic r; } smp_t;
  smp_t pipeQ[$];

  logic [11:0] heldCode = '0;
  logic        heldRand = 1'b0;
  logic        expValid = 1'b0;
  logic [11:0] prevCode = '0;
  logic        prevRand = 1'b0;
  logic        prevSeen = 1'b0;
  logic [6:0]  prevLsb  = '0;
  logic [2:0]  seenUnit = '0;
  logic [1:0]  seenTwo  = '0;

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lsbWeight(input logic [6:0] p);
    return p[0] + p[1] + p[2] + 2 * (p[3] + p[4]) + 4 * (p[5] + p[6]);
  endfunction

  // Reference timeline: the output after edge N reflects the input seen at edge N-1
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ.delete();
      heldCode = '0;
      heldRand = 1'b0;
      expValid = 1'b0;
    end else begin
      pipeQ.push_back('{validIn, dataIn, randEn});
      if (pipeQ.size() > 2) void'(pipeQ.pop_front());
      expValid = (pipeQ.size() == 2) && pipeQ[0].v;
      if (expValid) begin
        heldCode = pipeQ[0].c;
        heldRand = pipeQ[0].r;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic [254:0] expMsb;
      logic [6:0]   expId;
      int           m;
      string        holdTag;
      m = int'(heldCode[11:4]);
      for (int i = 0; i < 255; i++) expMsb[i] = (m > i);
      expId = idPat[heldCode[3:0]];
      holdTag = expValid ? "R2" : "R7";
      chk(validOut === expValid, "R6 validOut", $sformatf("%0b", validOut), $sformatf("%0b", expValid));
      chk(msbCtrl === expMsb, {holdTag, " msbCtrl"}, $sformatf("%0d ones", $countones(msbCtrl)),
          $sformatf("%0d ones (code %h)", m, heldCode));
      if (!heldRand) begin
        chk(lsbCtrl === expId, expValid ? "R3 lsbCtrl" : "R7 lsbCtrl",
            $sformatf("%h", lsbCtrl), $sformatf("%h", expId));
      end else begin
        chk($countones(lsbCtrl[2:0]) == $countones(expId[2:0]) &&
            $countones(lsbCtrl[4:3]) == $countones(expId[4:3]) &&
            $countones(lsbCtrl[6:5]) == $countones(expId[6:5]),
            "R4 group counts", $sformatf("%h", lsbCtrl), $sformatf("counts of %h", expId));
      end
      chk(16 * $countones(msbCtrl) + lsbWeight(lsbCtrl) == int'(heldCode), "R5 weight",
          $sformatf("%0d", 16 * $countones(msbCtrl) + lsbWeight(lsbCtrl)), $sformatf("%0d", heldCode));
      if (expValid) begin
        if (heldRand && heldCode == 12'd1) seenUnit = seenUnit | lsbCtrl[2:0];
        if (heldRand && heldCode == 12'd2) seenTwo  = seenTwo  | lsbCtrl[4:3];
        if (prevSeen && !prevRand && !heldRand && prevCode == 12'd7 && heldCode == 12'd8)
          chk($countones(prevLsb ^ lsbCtrl) <= 2, "R9 mid-step toggles",
              $sformatf("%0d", $countones(prevLsb ^ lsbCtrl)), "<=2");
        prevSeen = 1'b1;
        prevCode = heldCode;
        prevRand = heldRand;
        prevLsb  = lsbCtrl;
      end
    end
  end

  task automatic send(input logic [11:0] c, input logic v, input logic r);
    @(negedge clk);
    dataIn  = c;
    validIn = v;
    randEn  = r;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(msbCtrl === '0 && lsbCtrl === '0 && validOut === 1'b0, "R1 reset state",
        $sformatf("%0d/%h/%0b", $countones(msbCtrl), lsbCtrl, validOut), "0/00/0");
    rstN = 1'b1;
    // full sweep, identity mapping (R2, R3, R5)
    for (int c = 0; c < 4096; c++) send(12'(c), 1'b1, 1'b0);
    // idle gap: outputs must hold (R7)
    for (int k = 0; k < 4; k++) send(12'hABC, 1'b0, 1'b0);
    // full sweep, randomized (R4, R5)
    for (int c = 0; c < 4096; c++) send(12'(c), 1'b1, 1'b1);
    // sparse strobes with mixed modes (R6, R7)
    for (int k = 0; k < 600; k++)
      send(12'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    // rotation spread (R8)
    for (int k = 0; k < 48; k++) send(12'd1, 1'b1, 1'b1);
    for (int k = 0; k < 48; k++) send(12'd2, 1'b1, 1'b1);
    // mid-step in identity mode (R9)
    for (int k = 0; k < 3; k++) begin
      send(12'd7, 1'b1, 1'b0);
      send(12'd8, 1'b1, 1'b0);
    end
    for (int k = 0; k < 4; k++) send(12'd0, 1'b0, 1'b0);
    chk($countones(seenUnit) >= 2, "R8 unit rotation", $sformatf("%b", seenUnit), ">=2 positions");
    chk(seenTwo == 2'b11, "R8 weight-2 swap", $sformatf("%b", seenTwo), "11");
    finishRun();
  end

endmodule